// File: doc/BRIEF.md
# Dual-Half Timer with Variable-Width PWM

This block is a 16-bit timer that a processor programs through a small register port. The counter can act as two separate 8-bit interval timers, or as an 8-bit interval timer next to an 8-bit PWM generator, or as one 16-bit interval timer. In its fourth mode it is a single PWM generator whose period is a power of two, and software picks the exponent anywhere from 9 to 16.

Counting is driven by two enable inputs. `tick` is the normal one-per-step enable. `tick2x` runs at twice that rate and comes from the fast system clock. Only the two wide modes can switch to the double-rate enable, which gives them half-step resolution. Each half has a sticky event flag. Each flag has its own enable, and both feed one shared interrupt line. The PWM duty value is held in a shadow copy that is refreshed only at a period boundary, so a duty change written mid-period never produces a runt or stretched pulse.

Top module: `vpwm_timer`

## Requirements
- R1: After reset the control register, both enables, both flags and the counter are zero; `pwm_out` and `irq` are low.
- R2: While the run bit (control bit 2) is 0 the counter is held at zero and `pwm_out` is low.
- R3: Mode 0 (control bits [1:0] = 0): the low byte counts 0 up to the low match byte (address 1), giving a period of that value plus one steps, and sets the low flag as it wraps. The high byte does the same on its own against the high match byte (address 2) and sets the high flag.
- R4: Mode 1: the low byte is the R3 low timer. The high byte free-runs through 256 steps. `pwm_out` is high while the high byte is below the captured high match byte.
- R5: Mode 2: the full 16-bit count runs from 0 to {high match, low match} and then wraps, setting only the high flag; the low flag is never set in this mode.
- R6: Mode 3: with width select S (control bits [6:4]), W = 9 + S. The count wraps every 2^W steps and sets the high flag at the wrap. `pwm_out` is high while the count is below {high match, low match} masked to its low W bits.
- R7: The duty value is captured from the match registers only while stopped or at the step that ends a PWM period. A change written mid-period takes effect in the next period.
- R8: In modes 0 and 1 every step is taken from `tick`. In modes 2 and 3 a step is taken from `tick2x` when the fine bit (control bit 3) is 1, and from `tick` when it is 0.
- R9: Flags are sticky until software writes a 1 to address 3 bit 2 (low flag) or bit 3 (high flag). A set in the same cycle wins over a clear. `irq` is high when any flag is set and its enable (address 3 bit 0 low, bit 1 high) is 1.
- R10: Reads return the control register at address 0, the counter low and high bytes at addresses 1 and 2, and {high flag, low flag, high enable, low enable} in bits [3:0] at address 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Normal-rate count enable |
| tick2x | input | 1 | Double-rate count enable used for fine resolution |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | HALF_W (8) | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | HALF_W (8) | Register read data, combinational |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Shared interrupt request |

## Verification
The assertions assume that the mode and width select change only while the block is stopped. If the width were narrowed while running, the count could sit above the new mask for part of a period, and the mode-3 range property would not hold. The bench respects this by writing a zero control word before every new configuration and by changing only the match registers while the block runs. The enables are treated as single-cycle qualifiers sampled at the clock. The bench holds them constant within each test, so every step count, latency and PWM high-time has a fixed expected value.

// File: rtl/vpwm_pkg.sv
package vpwm_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT   = 2'd0,
        MODE_TMR_PWM = 2'd1,
        MODE_WIDE    = 2'd2,
        MODE_VARPWM  = 2'd3
    } mode_e;

    // control word: [6:4] width select, [3] fine, [2] run, [1:0] mode
    typedef struct packed {
        logic [2:0] wsel;
        logic       fine;
        logic       run;
        mode_e      mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_IRQ  = 2'd3;

endpackage

// File: rtl/vpwm_regs.sv
module vpwm_regs
    import vpwm_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              evt_lo,
    input  logic              evt_hi,
    output ctrl_t             ctrl,
    output logic [HALF_W-1:0] lmatch,
    output logic [HALF_W-1:0] hmatch,
    output logic              flag_lo,
    output logic              flag_hi,
    output logic [HALF_W-1:0] rd_data,
    output logic              irq
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [HALF_W-1:0] lm;
        logic [HALF_W-1:0] hm;
        logic              ien_lo;
        logic              ien_hi;
        logic              fl_lo;
        logic              fl_hi;
    } regs_t;

    regs_t q, d;
    logic  clr_lo, clr_hi;

    always_comb begin
        d      = q;
        clr_lo = 1'b0;
        clr_hi = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_LO:   d.lm   = wr_data;
                ADDR_HI:   d.hm   = wr_data;
                default: begin
                    d.ien_lo = wr_data[0];
                    d.ien_hi = wr_data[1];
                    clr_lo   = wr_data[2];
                    clr_hi   = wr_data[3];
                end
            endcase
        end
        // a new event in the same cycle outranks a software clear
        d.fl_lo = (q.fl_lo & ~clr_lo) | evt_lo;
        d.fl_hi = (q.fl_hi & ~clr_hi) | evt_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = HALF_W'(q.ctrl);
            ADDR_LO:   rd_data = cnt[HALF_W-1:0];
            ADDR_HI:   rd_data = cnt[CNT_W-1:HALF_W];
            default:   rd_data = HALF_W'({q.fl_hi, q.fl_lo, q.ien_hi, q.ien_lo});
        endcase
    end

    assign ctrl    = q.ctrl;
    assign lmatch  = q.lm;
    assign hmatch  = q.hm;
    assign flag_lo = q.fl_lo;
    assign flag_hi = q.fl_hi;
    assign irq     = (q.fl_lo & q.ien_lo) | (q.fl_hi & q.ien_hi);

endmodule

// File: rtl/vpwm_count.sv
module vpwm_count
    import vpwm_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W,
    localparam int SH_W  = $clog2(CNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl,
    input  logic [HALF_W-1:0] lmatch,
    input  logic [HALF_W-1:0] hmatch,
    input  logic              tick,
    input  logic              tick2x,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  mask,
    output logic              evt_lo,
    output logic              evt_hi,
    output logic              bound
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t              q, d;
    logic              step;
    logic [SH_W-1:0]   drop;
    logic [HALF_W-1:0] lo, hi, lo_nx, hi_nx;

    // W = HALF_W + 1 + wsel, clamped to the full count width
    always_comb begin
        if (SH_W'(ctrl.wsel) >= SH_W'(HALF_W - 1)) drop = '0;
        else drop = SH_W'(HALF_W - 1) - SH_W'(ctrl.wsel);
        mask = {CNT_W{1'b1}} >> drop;
    end

    assign step = ctrl.run & ((ctrl.fine & ctrl.mode[1]) ? tick2x : tick);
    assign lo   = q.cnt[HALF_W-1:0];
    assign hi   = q.cnt[CNT_W-1:HALF_W];

    always_comb begin
        d      = q;
        evt_lo = 1'b0;
        evt_hi = 1'b0;
        bound  = 1'b0;
        lo_nx  = lo;
        hi_nx  = hi;
        if (!ctrl.run) begin
            d.cnt = '0;
        end else if (step) begin
            case (ctrl.mode)
                MODE_SPLIT: begin
                    if (lo == lmatch) begin lo_nx = '0; evt_lo = 1'b1; end
                    else lo_nx = lo + 1'b1;
                    if (hi == hmatch) begin hi_nx = '0; evt_hi = 1'b1; end
                    else hi_nx = hi + 1'b1;
                    d.cnt = {hi_nx, lo_nx};
                end
                MODE_TMR_PWM: begin
                    if (lo == lmatch) begin lo_nx = '0; evt_lo = 1'b1; end
                    else lo_nx = lo + 1'b1;
                    hi_nx = hi + 1'b1;
                    if (hi == {HALF_W{1'b1}}) begin evt_hi = 1'b1; bound = 1'b1; end
                    d.cnt = {hi_nx, lo_nx};
                end
                MODE_WIDE: begin
                    if (q.cnt == {hmatch, lmatch}) begin d.cnt = '0; evt_hi = 1'b1; end
                    else d.cnt = q.cnt + 1'b1;
                end
                default: begin
                    if ((q.cnt & mask) == mask) begin
                        d.cnt  = '0;
                        evt_hi = 1'b1;
                        bound  = 1'b1;
                    end else begin
                        d.cnt = (q.cnt + 1'b1) & mask;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;

endmodule

// File: rtl/vpwm_pwm.sv
module vpwm_pwm
    import vpwm_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  mode_e             mode,
    input  logic [HALF_W-1:0] lmatch,
    input  logic [HALF_W-1:0] hmatch,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  mask,
    input  logic              bound,
    output logic [CNT_W-1:0]  duty,
    output logic              pwm_out
);

    typedef struct packed {
        logic [CNT_W-1:0] duty;
    } pwm_t;

    pwm_t q, d;

    // raw match pair is captured; width masking happens at the compare
    always_comb begin
        d = q;
        if (!run || bound) d.duty = {hmatch, lmatch};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (mode)
            MODE_VARPWM:  pwm_out = run & (cnt < (q.duty & mask));
            MODE_TMR_PWM: pwm_out = run & (cnt[CNT_W-1:HALF_W] < q.duty[CNT_W-1:HALF_W]);
            default:      pwm_out = 1'b0;
        endcase
    end

    assign duty = q.duty;

endmodule

// File: rtl/vpwm_timer.sv
module vpwm_timer
    import vpwm_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tick2x,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              pwm_out,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [HALF_W-1:0] lmatch, hmatch;
    logic [CNT_W-1:0]  cnt, mask, duty;
    logic              evt_lo, evt_hi, bound;
    logic              flag_lo, flag_hi;

    vpwm_regs #(.HALF_W(HALF_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .cnt     (cnt),
        .evt_lo  (evt_lo),
        .evt_hi  (evt_hi),
        .ctrl    (ctrl),
        .lmatch  (lmatch),
        .hmatch  (hmatch),
        .flag_lo (flag_lo),
        .flag_hi (flag_hi),
        .rd_data (rd_data),
        .irq     (irq)
    );

    vpwm_count #(.HALF_W(HALF_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .lmatch (lmatch),
        .hmatch (hmatch),
        .tick   (tick),
        .tick2x (tick2x),
        .cnt    (cnt),
        .mask   (mask),
        .evt_lo (evt_lo),
        .evt_hi (evt_hi),
        .bound  (bound)
    );

    vpwm_pwm #(.HALF_W(HALF_W)) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .mode    (ctrl.mode),
        .lmatch  (lmatch),
        .hmatch  (hmatch),
        .cnt     (cnt),
        .mask    (mask),
        .bound   (bound),
        .duty    (duty),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/vpwm_checker.sv
module vpwm_checker
    import vpwm_pkg::*;
#(
    parameter int HALF_W = 8,
    localparam int CNT_W = 2 * HALF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             clr_req,
    input logic             run,
    input mode_e            mode,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mask,
    input logic [CNT_W-1:0] duty,
    input logic             flag_lo
);

    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    p_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !mode[1] && !tick) |=> $stable(cnt));

    p_wide_no_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_WIDE && !flag_lo) |=> !flag_lo);

    p_var_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_VARPWM) |-> ((cnt & ~mask) == '0));

    p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_VARPWM && (cnt & mask) != mask) |=> $stable(duty));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && !(wr_en && wr_addr == ADDR_IRQ && clr_req)) |=> flag_lo);

endmodule

bind vpwm_timer vpwm_checker #(.HALF_W(HALF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .clr_req (wr_data[2]),
    .run     (ctrl.run),
    .mode    (ctrl.mode),
    .cnt     (cnt),
    .mask    (mask),
    .duty    (duty),
    .flag_lo (flag_lo)
);

// File: tb/tb_vpwm_timer.sv
module tb_vpwm_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       tick2x = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_out;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int hi_tot = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    exp;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    vpwm_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tick2x(tick2x),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out), .irq(irq)
    );

    // PWM high-time accumulator, sampled at the falling edge
    always @(negedge clk) if (rst_n) hi_tot <= hi_tot + int'(pwm_out);

    task automatic push_exp(input string tag, input int exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic observe(input int act);
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (act != it.exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic latency(output int n);
        n = 0;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic halt_and_clear();
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h0C);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R10 reset state
        rd(2'd0, v); push_exp("R1 ctrl after reset", 0); observe(v);
        rd(2'd3, v); push_exp("R1 flags after reset", 0); observe(v);
        push_exp("R1 pwm after reset", 0); observe(int'(pwm_out));
        push_exp("R1 irq after reset", 0); observe(int'(irq));

        // R3 split mode, high half interrupt
        wr(2'd1, 8'd4); wr(2'd2, 8'd2); wr(2'd3, 8'h02); wr(2'd0, 8'h04);
        latency(v); push_exp("R3 high half period", 3); observe(v);
        rd(2'd3, v); push_exp("R10 flag/enable readback", 8'h0A); observe(v);
        halt_and_clear();
        push_exp("R2 irq after stop", 0); observe(int'(irq));
        rd(2'd1, v); push_exp("R2 counter held at zero", 0); observe(v);
        push_exp("R2 pwm low when stopped", 0); observe(int'(pwm_out));

        // R3 split mode, low half interrupt
        wr(2'd3, 8'h01); wr(2'd0, 8'h04);
        latency(v); push_exp("R3 low half period", 5); observe(v);
        halt_and_clear();

        // R9 set wins over clear, enable masking
        wr(2'd1, 8'd0); wr(2'd3, 8'h01); wr(2'd0, 8'h04);
        repeat (2) @(negedge clk);
        wr(2'd3, 8'h05);
        rd(2'd3, v); push_exp("R9 set beats clear", 1); observe((v >> 2) & 1);
        push_exp("R9 irq with enabled flag", 1); observe(int'(irq));
        wr(2'd3, 8'h00);
        push_exp("R9 irq masked by enable", 0); observe(int'(irq));
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h04);
        rd(2'd3, v); push_exp("R9 clear drops low flag", 0); observe((v >> 2) & 1);
        halt_and_clear();

        // R4 timer plus 8-bit PWM
        wr(2'd1, 8'd9); wr(2'd2, 8'h40); wr(2'd0, 8'h05);
        a = hi_tot; repeat (256) @(negedge clk); b = hi_tot;
        push_exp("R4 pwm8 high time", 64); observe(b - a);
        rd(2'd3, v); push_exp("R4 low timer flag", 1); observe((v >> 2) & 1);
        halt_and_clear();

        // R8 fine bit has no effect in split mode
        tick = 1'b0;
        wr(2'd1, 8'd4); wr(2'd0, 8'h0C);
        repeat (20) @(negedge clk);
        rd(2'd1, v); push_exp("R8 split ignores tick2x", 0); observe(v);
        halt_and_clear();
        tick = 1'b1;

        // R5 16-bit timer
        wr(2'd1, 8'h05); wr(2'd2, 8'h01); wr(2'd3, 8'h02); wr(2'd0, 8'h06);
        latency(v); push_exp("R5 wide period", 262); observe(v);
        rd(2'd3, v); push_exp("R5 no low flag", 0); observe((v >> 2) & 1);
        halt_and_clear();

        // R8 fine resolution in wide mode
        tick = 1'b0;
        wr(2'd3, 8'h02); wr(2'd0, 8'h0E);
        latency(v); push_exp("R8 fine uses tick2x", 262); observe(v);
        halt_and_clear();
        wr(2'd3, 8'h02); wr(2'd0, 8'h06);
        repeat (300) @(negedge clk);
        push_exp("R8 coarse waits for tick", 0); observe(int'(irq));
        rd(2'd1, v); push_exp("R8 coarse counter idle", 0); observe(v);
        halt_and_clear();
        tick = 1'b1;

        // R6 / R7 variable PWM, W = 9, duty masked to 9 bits
        wr(2'd1, 8'h80); wr(2'd2, 8'h03); wr(2'd3, 8'h00); wr(2'd0, 8'h07);
        a = hi_tot;
        repeat (100) @(negedge clk);
        wr(2'd1, 8'h40); wr(2'd2, 8'h00);
        repeat (410) @(negedge clk);
        b = hi_tot;
        push_exp("R6 W9 masked duty high time", 384); observe(b - a);
        a = b; repeat (512) @(negedge clk); b = hi_tot;
        push_exp("R7 new duty in next period", 64); observe(b - a);
        rd(2'd3, v); push_exp("R6 boundary sets high flag", 1); observe((v >> 3) & 1);
        halt_and_clear();

        // R6 W = 10
        wr(2'd1, 8'h80); wr(2'd2, 8'h03); wr(2'd0, 8'h17);
        a = hi_tot; repeat (1024) @(negedge clk); b = hi_tot;
        push_exp("R6 W10 high time", 896); observe(b - a);
        rd(2'd0, v); push_exp("R10 control readback", 8'h17); observe(v);
        halt_and_clear();
        push_exp("R2 pwm low after stop", 0); observe(int'(pwm_out));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule